// File: doc/BRIEF.md
# Burst-Inhibited Line Transfer Sequencer

This block is the bus-master side of a 16-byte line access whose first beat came back with a burst-inhibit response. The slave would not take a burst. The sequencer completes the line as three more single long-word cycles. Each cycle has its own start strobe, a long-word size code and a status strobe. The two word-select address bits advance between cycles and wrap, so every long word of the line is visited exactly once. The upper address bits stay fixed.

The surrounding bus controller raises `start_i` for one clock once it sees the burst-inhibit response on the first beat. With that pulse it supplies the line address, the direction, the lock flags, the first word read, the full write line and the acknowledge-ignore setting. The status strobe comes out in the same cycle as the start strobe when ignoring is off. When ignoring is on, it comes a programmed number of clocks later, and acknowledges are refused until that point. Reads assemble the four words into a 128-bit line. Writes drive the matching long word and release the data bus after each acknowledge. When the fourth long word completes, a one-clock done pulse is raised, the lock indicators drop, and transfer-in-progress either falls or is handed to a queued next cycle.

Top module: `line_split_seq`

## Requirements
- R1: After a one-clock `start_i` in idle, the block runs exactly three follow-on beats (three `ts_o` pulses) and then raises `done_o`. A `start_i` seen while busy is ignored.
- R2: `ts_o` is high for exactly one clock per beat: in the clock after `start_i` for the first follow-on beat, and in the clock after an accepted acknowledge for the others.
- R3: During beat n (n = 1..3), `addr_o[3:2]` equals (`line_addr_i[3:2]` + n) mod 4. `addr_o[1:0]` is 0, and `addr_o[31:4]` equals `line_addr_i[31:4]` as latched at start.
- R4: During every beat `siz_o` carries the long-word code 2'b00.
- R5: Let N be `ign_val_i` when `ign_en_i` is 1, and 0 otherwise, both latched at start. `stat_o` is high for one clock per beat, N clocks after the `ts_o` clock (the same clock when N = 0).
- R6: `ta_i` is accepted only in wait clocks that come after the clock in which `stat_o` was high. An acknowledge outside those clocks neither ends the beat nor captures data.
- R7: For a read line, `line_o[32k+31:32k]` holds the long word at word offset k when `done_o` is high. The start offset takes `first_data_i`, and each other offset takes `data_i` from its accepted acknowledge.
- R8: For a write line, `data_oe_o` is high in every wait clock, with `data_o` equal to `wline_i[32k+31:32k]` for the beat's offset k. It is low in `ts_o` clocks and in the clock after each accepted acknowledge.
- R9: `line_ci_o` at `done_o` is the OR of `ci_i` over accepted read acknowledges. On write lines `ci_i` is ignored and `line_ci_o` is 0.
- R10: During beats, `lock_o` and `lock_end_o` follow the values latched from `locked_i` and `lock_last_i`. `done_o` pulses for one clock, the clock after the fourth long word's acknowledge, and both lock outputs are low in that clock.
- R11: `tip_o` is high from the first `ts_o` through the last acknowledge. In the `done_o` clock it equals `next_req_i` as sampled with the last acknowledge, and `next_start_o` pulses with the same value. Afterwards it is low.
- R12: Reset (synchronous, active high) gives idle with `ts_o`, `stat_o`, `tip_o`, `data_oe_o`, `lock_o`, `lock_end_o` and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | First beat was burst-inhibited; begin follow-on beats |
| line_addr_i | input | ADDR_W | Address of the first beat |
| write_i | input | 1 | 1 for a write line, 0 for a read line |
| locked_i | input | 1 | Lock indicator active for this line |
| lock_last_i | input | 1 | Lock-end indicator active for this line |
| first_data_i | input | DATA_W | Word captured by the first beat (reads) |
| wline_i | input | 4*DATA_W | Write line, word k at bits 32k+31:32k |
| ign_en_i | input | 1 | Acknowledge-ignore enabled |
| ign_val_i | input | IGN_W | Ignore-state count |
| next_req_i | input | 1 | Another cycle is queued |
| ts_o | output | 1 | Transfer-start strobe |
| stat_o | output | 1 | Status strobe |
| siz_o | output | 2 | Size code |
| addr_o | output | ADDR_W | Beat address |
| read_o | output | 1 | Read beat in progress |
| tip_o | output | 1 | Transfer in progress |
| lock_o | output | 1 | Lock indicator |
| lock_end_o | output | 1 | Lock-end indicator |
| data_o | output | DATA_W | Write data |
| data_oe_o | output | 1 | Write data enable |
| data_i | input | DATA_W | Read data |
| ta_i | input | 1 | Transfer acknowledge |
| ci_i | input | 1 | Cache-inhibit from the slave |
| done_o | output | 1 | Line finished, one clock |
| line_o | output | 4*DATA_W | Assembled read line |
| line_ci_o | output | 1 | Some read beat was cache-inhibited |
| next_start_o | output | 1 | Next queued cycle takes over the bus |

## Verification
Faults in internal state show up at the ports quickly. If the word-select register is wrong, the next `ts_o` clock carries the wrong `addr_o[3:2]`, and the same word also shows up on `data_o` or in the wrong slot of `line_o`. An ignore counter that is off by one moves `stat_o` a clock away from its expected position within the same beat. It also lets an acknowledge driven in an ignored clock through, so a `ts_o` or `done_o` appears at least one clock early. A wrong beat count moves `done_o` a whole beat early or late, and a stale lock or handoff flag shows in the one `done_o` clock.

// File: rtl/line_seq_pkg.sv
package line_seq_pkg;

    localparam int LINE_WORDS   = 4;
    localparam int WSEL_W       = $clog2(LINE_WORDS);
    localparam int WSEL_LSB     = 2;
    localparam int FOLLOW_BEATS = LINE_WORDS - 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    typedef struct packed {
        logic write;
        logic locked;
        logic lock_last;
    } line_ctl_t;

    function automatic logic [WSEL_W-1:0] wsel_advance(input logic [WSEL_W-1:0] w);
        return w + WSEL_W'(1);
    endfunction

endpackage

// File: rtl/lss_word_stepper.sv
module lss_word_stepper
    import line_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WSEL_W-1:0] word_o,
    output logic              last_o
);
    localparam int HI_LSB = WSEL_LSB + WSEL_W;
    localparam int CNT_W  = $clog2(LINE_WORDS);

    logic [ADDR_W-HI_LSB-1:0] hi_q;
    logic [WSEL_W-1:0]        word_q;
    logic [CNT_W-1:0]         acks_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            word_q <= '0;
            acks_q <= '0;
        end else if (load_i) begin
            hi_q   <= base_i[ADDR_W-1:HI_LSB];
            word_q <= wsel_advance(base_i[HI_LSB-1:WSEL_LSB]);
            acks_q <= '0;
        end else if (step_i) begin
            word_q <= wsel_advance(word_q);
            acks_q <= acks_q + CNT_W'(1);
        end
    end

    assign addr_o = {hi_q, word_q, {WSEL_LSB{1'b0}}};
    assign word_o = word_q;
    assign last_o = (acks_q == CNT_W'(FOLLOW_BEATS - 1));

    // R3: the first follow-on word never repeats the starting word
    a_r3_word_moves: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (word_o != $past(base_i[HI_LSB-1:WSEL_LSB])));

    // R1: no step beyond the last follow-on beat
    a_r1_step_bound: assert property (@(posedge clk) disable iff (rst)
        step_i |-> (acks_q <= CNT_W'(FOLLOW_BEATS - 1)));

endmodule

// File: rtl/lss_ignore_timer.sv
module lss_ignore_timer
    import line_seq_pkg::*;
#(
    parameter int IGN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             en_i,
    input  logic [IGN_W-1:0] val_i,
    output logic             stat_o,
    output logic             open_o
);
    logic [IGN_W-1:0] cnt_q;
    logic [IGN_W-1:0] eff;
    logic             pend_q;

    assign eff    = en_i ? val_i : '0;
    assign stat_o = (arm_i && (eff == '0)) || (pend_q && (cnt_q == '0));
    assign open_o = !arm_i && !pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (arm_i) begin
            pend_q <= (eff != '0);
            cnt_q  <= eff - IGN_W'(1);
        end else if (pend_q) begin
            if (cnt_q == '0) pend_q <= 1'b0;
            else             cnt_q  <= cnt_q - IGN_W'(1);
        end
    end

    // R5: one status strobe per beat, never on consecutive clocks
    a_r5_stat_single: assert property (@(posedge clk) disable iff (rst)
        stat_o |=> !stat_o);

    // R5: a delayed strobe is always preceded by an arm or a pending count
    a_r5_stat_origin: assert property (@(posedge clk) disable iff (rst)
        (stat_o && !arm_i) |-> ($past(arm_i) || $past(pend_q)));

endmodule

// File: rtl/lss_line_buf.sv
module lss_line_buf
    import line_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_i,
    input  logic                         load_rd_i,
    input  logic [WSEL_W-1:0]            init_sel_i,
    input  logic [DATA_W-1:0]            init_data_i,
    input  logic [LINE_WORDS*DATA_W-1:0] wline_i,
    input  logic                         cap_i,
    input  logic [WSEL_W-1:0]            sel_i,
    input  logic [DATA_W-1:0]            cap_data_i,
    output logic [LINE_WORDS*DATA_W-1:0] line_o,
    output logic [DATA_W-1:0]            wword_o
);
    localparam int LINE_W = LINE_WORDS * DATA_W;

    logic [LINE_W-1:0] wr_flat;

    for (genvar k = 0; k < LINE_WORDS; k++) begin : g_slot
        logic [DATA_W-1:0] rd_q;
        logic [DATA_W-1:0] wr_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q <= '0;
                wr_q <= '0;
            end else begin
                if (load_i) wr_q <= wline_i[k*DATA_W +: DATA_W];
                if (load_rd_i && (init_sel_i == WSEL_W'(k)))
                    rd_q <= init_data_i;
                else if (cap_i && (sel_i == WSEL_W'(k)))
                    rd_q <= cap_data_i;
            end
        end

        assign line_o[k*DATA_W +: DATA_W]  = rd_q;
        assign wr_flat[k*DATA_W +: DATA_W] = wr_q;
    end

    assign wword_o = wr_flat[sel_i*DATA_W +: DATA_W];

endmodule

// File: rtl/line_split_seq.sv
module line_split_seq
    import line_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IGN_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic [ADDR_W-1:0]            line_addr_i,
    input  logic                         write_i,
    input  logic                         locked_i,
    input  logic                         lock_last_i,
    input  logic [DATA_W-1:0]            first_data_i,
    input  logic [LINE_WORDS*DATA_W-1:0] wline_i,
    input  logic                         ign_en_i,
    input  logic [IGN_W-1:0]             ign_val_i,
    input  logic                         next_req_i,
    output logic                         ts_o,
    output logic                         stat_o,
    output logic [1:0]                   siz_o,
    output logic [ADDR_W-1:0]            addr_o,
    output logic                         read_o,
    output logic                         tip_o,
    output logic                         lock_o,
    output logic                         lock_end_o,
    output logic [DATA_W-1:0]            data_o,
    output logic                         data_oe_o,
    input  logic [DATA_W-1:0]            data_i,
    input  logic                         ta_i,
    input  logic                         ci_i,
    output logic                         done_o,
    output logic [LINE_WORDS*DATA_W-1:0] line_o,
    output logic                         line_ci_o,
    output logic                         next_start_o
);
    seq_state_e        state_q;
    line_ctl_t         ctl_q;
    logic              ign_en_q;
    logic [IGN_W-1:0]  ign_val_q;
    logic              done_q;
    logic              hand_q;
    logic              line_ci_q;

    logic              busy;
    logic              issue;
    logic              launch;
    logic              ack;
    logic              win_open;
    logic              last_beat;
    logic [WSEL_W-1:0] word;
    logic [DATA_W-1:0] wword;

    assign busy   = (state_q != ST_IDLE);
    assign issue  = (state_q == ST_ISSUE);
    assign launch = (state_q == ST_IDLE) && start_i;
    assign ack    = (state_q == ST_WAIT) && ta_i && win_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctl_q     <= '0;
            ign_en_q  <= 1'b0;
            ign_val_q <= '0;
            done_q    <= 1'b0;
            hand_q    <= 1'b0;
            line_ci_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q   <= ST_ISSUE;
                        ctl_q     <= '{write: write_i, locked: locked_i, lock_last: lock_last_i};
                        ign_en_q  <= ign_en_i;
                        ign_val_q <= ign_val_i;
                        line_ci_q <= 1'b0;
                        hand_q    <= 1'b0;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (ack) begin
                        if (!ctl_q.write && ci_i) line_ci_q <= 1'b1;
                        if (last_beat) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            hand_q  <= next_req_i;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    lss_word_stepper #(.ADDR_W(ADDR_W)) u_step (
        .clk    (clk),
        .rst    (rst),
        .load_i (launch),
        .base_i (line_addr_i),
        .step_i (ack),
        .addr_o (addr_o),
        .word_o (word),
        .last_o (last_beat)
    );

    lss_ignore_timer #(.IGN_W(IGN_W)) u_ign (
        .clk    (clk),
        .rst    (rst),
        .arm_i  (issue),
        .en_i   (ign_en_q),
        .val_i  (ign_val_q),
        .stat_o (stat_o),
        .open_o (win_open)
    );

    lss_line_buf #(.DATA_W(DATA_W)) u_buf (
        .clk         (clk),
        .rst         (rst),
        .load_i      (launch),
        .load_rd_i   (launch && !write_i),
        .init_sel_i  (line_addr_i[WSEL_LSB +: WSEL_W]),
        .init_data_i (first_data_i),
        .wline_i     (wline_i),
        .cap_i       (ack && !ctl_q.write),
        .sel_i       (word),
        .cap_data_i  (data_i),
        .line_o      (line_o),
        .wword_o     (wword)
    );

    assign ts_o         = issue;
    assign siz_o        = SZ_LONG;
    assign read_o       = busy && !ctl_q.write;
    assign tip_o        = busy || (done_q && hand_q);
    assign lock_o       = busy && ctl_q.locked;
    assign lock_end_o   = busy && ctl_q.lock_last;
    assign data_oe_o    = (state_q == ST_WAIT) && ctl_q.write;
    assign data_o       = wword;
    assign done_o       = done_q;
    assign line_ci_o    = line_ci_q;
    assign next_start_o = done_q && hand_q;

    // R2: start strobe lasts a single clock
    a_r2_ts_single: assert property (@(posedge clk) disable iff (rst)
        ts_o |=> !ts_o);

    // R10: done is a one-clock pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: lock indicators are negated when the line completes
    a_r10_locks_clear: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!lock_o && !lock_end_o));

    // R8: write data released the clock after an accepted acknowledge
    a_r8_bus_release: assert property (@(posedge clk) disable iff (rst)
        (ack && ctl_q.write) |=> !data_oe_o);

    // R12: without a transfer in progress no strobe or data drive appears
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !tip_o |-> (!ts_o && !stat_o && !data_oe_o));

endmodule

// File: tb/line_split_seq_tb_top.sv
module line_split_seq_tb_top;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int IGN_W  = 4;

    logic                clk = 1'b0;
    logic                rst;
    logic                start_i;
    logic [ADDR_W-1:0]   line_addr_i;
    logic                write_i, locked_i, lock_last_i;
    logic [DATA_W-1:0]   first_data_i;
    logic [4*DATA_W-1:0] wline_i;
    logic                ign_en_i;
    logic [IGN_W-1:0]    ign_val_i;
    logic                next_req_i;
    logic                ts_o, stat_o, read_o, tip_o, lock_o, lock_end_o;
    logic [1:0]          siz_o;
    logic [ADDR_W-1:0]   addr_o;
    logic [DATA_W-1:0]   data_o;
    logic                data_oe_o;
    logic [DATA_W-1:0]   data_i;
    logic                ta_i, ci_i;
    logic                done_o, line_ci_o, next_start_o;
    logic [4*DATA_W-1:0] line_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    line_split_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IGN_W(IGN_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .line_addr_i(line_addr_i),
        .write_i(write_i), .locked_i(locked_i), .lock_last_i(lock_last_i),
        .first_data_i(first_data_i), .wline_i(wline_i), .ign_en_i(ign_en_i),
        .ign_val_i(ign_val_i), .next_req_i(next_req_i), .ts_o(ts_o),
        .stat_o(stat_o), .siz_o(siz_o), .addr_o(addr_o), .read_o(read_o),
        .tip_o(tip_o), .lock_o(lock_o), .lock_end_o(lock_end_o),
        .data_o(data_o), .data_oe_o(data_oe_o), .data_i(data_i), .ta_i(ta_i),
        .ci_i(ci_i), .done_o(done_o), .line_o(line_o), .line_ci_o(line_ci_o),
        .next_start_o(next_start_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rword(input int n, input int k);
        return 32'hC0DE_0000 ^ (n << 8) ^ k;
    endfunction

    function automatic logic [31:0] wword(input int n, input int k);
        return 32'h5A00_0000 ^ (n << 4) ^ (k * 32'h1111);
    endfunction

    task automatic run_line(input int n, input int off, input bit wr, input bit ien,
                            input int ival, input int lat, input bit nreq, input bit lk);
        logic [31:0] base;
        int          eff;
        bit          ci_acc;
        base = 32'h0040_0000 + n * 32'h100;
        eff  = ien ? ival : 0;
        ci_acc = 1'b0;
        start_i      = 1'b1;
        line_addr_i  = base + off * 4;
        write_i      = wr;
        locked_i     = lk;
        lock_last_i  = lk;
        first_data_i = rword(n, off);
        for (int k = 0; k < 4; k++) wline_i[k*32 +: 32] = wword(n, k);
        ign_en_i     = ien;
        ign_val_i    = IGN_W'(ival);
        next_req_i   = nreq;
        ta_i         = 1'b0;
        ci_i         = 1'b0;
        @(negedge clk);
        start_i     = 1'b0;
        line_addr_i = '1;
        ign_val_i   = '0;
        ign_en_i    = ~ien;
        for (int b = 1; b <= 3; b++) begin
            int w;
            int target;
            w = (off + b) % 4;
            target = eff + 1 + lat;
            chk(ts_o == 1'b1, "R2", "ts at beat start", 64'(ts_o), 1);
            chk(addr_o == base + w * 4, "R3", "beat address", 64'(addr_o), 64'(base + w * 4));
            chk(siz_o == 2'b00, "R4", "size code", 64'(siz_o), 0);
            chk(tip_o == 1'b1 && read_o == !wr, "R11", "tip/read in beat",
                64'({tip_o, read_o}), 64'({1'b1, !wr}));
            chk(lock_o == lk && lock_end_o == lk, "R10", "lock during beat",
                64'({lock_o, lock_end_o}), 64'({lk, lk}));
            chk(data_oe_o == 1'b0, "R8", "no drive in ts clock", 64'(data_oe_o), 0);
            chk(stat_o == (eff == 0), "R5", "stat in ts clock", 64'(stat_o), 64'(eff == 0));
            for (int k = 1; ; k++) begin
                @(negedge clk);
                chk(ts_o == 1'b0, "R6", "no early ts in wait", 64'(ts_o), 0);
                chk(stat_o == (eff != 0 && k == eff), "R5", "stat timing",
                    64'(stat_o), 64'(eff != 0 && k == eff));
                chk(done_o == 1'b0, "R1", "no early done", 64'(done_o), 0);
                if (wr) begin
                    chk(data_oe_o == 1'b1, "R8", "drive in wait", 64'(data_oe_o), 1);
                    chk(data_o == wword(n, w), "R8", "write word", 64'(data_o), 64'(wword(n, w)));
                end
                if (k == target) begin
                    ta_i   = 1'b1;
                    data_i = rword(n, w);
                    ci_i   = wr ? 1'b1 : ((n % 3 == 0) && b == 2);
                    if (!wr && (n % 3 == 0) && b == 2) ci_acc = 1'b1;
                    start_i = 1'b1;
                    break;
                end else if (eff >= 1 && (k == 1 || k == eff)) begin
                    ta_i   = 1'b1;
                    data_i = 32'hDEAD_BEEF;
                    ci_i   = 1'b1;
                end else begin
                    ta_i = 1'b0;
                    ci_i = 1'b0;
                end
            end
            @(negedge clk);
            ta_i    = 1'b0;
            ci_i    = 1'b0;
            start_i = 1'b0;
            chk(wr == 0 || data_oe_o == 1'b0, "R8", "release after ack", 64'(data_oe_o), 0);
        end
        chk(done_o == 1'b1, "R10", "done after fourth word", 64'(done_o), 1);
        chk(ts_o == 1'b0, "R1", "no fourth follow-on ts", 64'(ts_o), 0);
        chk(lock_o == 1'b0 && lock_end_o == 1'b0, "R10", "locks negated",
            64'({lock_o, lock_end_o}), 0);
        chk(tip_o == nreq, "R11", "tip at done", 64'(tip_o), 64'(nreq));
        chk(next_start_o == nreq, "R11", "handoff pulse", 64'(next_start_o), 64'(nreq));
        chk(line_ci_o == ci_acc, "R9", "line cache-inhibit", 64'(line_ci_o), 64'(ci_acc));
        if (!wr) begin
            for (int k = 0; k < 4; k++)
                chk(line_o[k*32 +: 32] == rword(n, k), "R7", "line word",
                    64'(line_o[k*32 +: 32]), 64'(rword(n, k)));
        end
        @(negedge clk);
        chk(done_o == 1'b0 && tip_o == 1'b0 && next_start_o == 1'b0, "R11", "idle after done",
            64'({done_o, tip_o, next_start_o}), 0);
        chk(ts_o == 1'b0, "R1", "start while busy ignored", 64'(ts_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; start_i = 1'b0; line_addr_i = '0; write_i = 1'b0;
        locked_i = 1'b0; lock_last_i = 1'b0; first_data_i = '0; wline_i = '0;
        ign_en_i = 1'b0; ign_val_i = '0; next_req_i = 1'b0; data_i = '0;
        ta_i = 1'b0; ci_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({ts_o, stat_o, tip_o, data_oe_o, lock_o, lock_end_o, done_o} == 7'b0, "R12",
            "reset state", 64'({ts_o, stat_o, tip_o, data_oe_o, lock_o, lock_end_o, done_o}), 0);
        n = 0;
        for (int off = 0; off < 4; off++)
            for (int wr = 0; wr < 2; wr++)
                for (int ien = 0; ien < 2; ien++)
                    for (int vi = 0; vi < 3; vi++)
                        for (int lat = 0; lat < 2; lat++) begin
                            run_line(n, off, wr[0], ien[0], (vi == 0) ? 0 : (vi == 1) ? 2 : 5,
                                     lat, n[0], n[1]);
                            n++;
                        end
        run_line(n, 3, 1'b0, 1'b1, 15, 1, 1'b1, 1'b1);
        n++;
        run_line(n, 1, 1'b1, 1'b1, 15, 0, 1'b0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule